// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block rewrites request addresses from the CPU side into bus-side addresses for outgoing transactions. It holds a small set of programmable outbound regions. Each region has a 64-bit base split into two words, a 32-bit upper bound on the low address word, a 64-bit target split into two words, a transaction kind and an enable bit. For every request address the block finds the enabled region whose window contains it. It then returns the translated address, the kind of that region and a hit flag, all in the same cycle as the request.

Software does not reach the regions through a flat map. It first writes a selector register that names one region and a direction. All later window accesses then land in that region. This lets software keep a region in use and reprogram it between accesses, for example to switch it from configuration use to memory or I/O use. For configuration kinds the target's low word carries the bus number in bits 31:24, the device in bits 23:19 and the function in bits 18:16. These fields travel through the translation unchanged as long as the offset into the window stays below 64 KiB.

Top module: `atu_outbound`

## Requirements
- R1: After reset every region is disabled with all fields zero, the selector reads 0 and no request hits.
- R2: The selector sits at offset 0x900. Bit 31 is the direction (1 = inbound, 0 = outbound) and bits 3:0 are the region index. Reading it returns those bits, with all other bits zero.
- R3: Window writes change only the region picked by the selector, and window reads return that region's fields. The offsets are 0x90C base low, 0x910 base high, 0x914 upper bound, 0x918 target low and 0x91C target high. Any offset outside the map reads as zero.
- R4: Offset 0x904 holds the kind in bits 2:0 (0 memory, 2 I/O, 4 type-0 configuration, 5 type-1 configuration), and reads return it with the other bits zero.
- R5: Offset 0x908 bit 31 enables the region. Bit 30 and every other bit are discarded: they read as zero and have no effect on translation.
- R6: A region matches when it is enabled, the upper request word equals its base high, and the low request word lies between base low and the upper bound, both ends included.
- R7: On a match the output address is the region's 64-bit target plus (request − 64-bit base), computed modulo 2^64 with carries crossing bit 32. The output kind is the region's kind. For configuration kinds the bus, device and function in target bits 31:16 appear unchanged for offsets below 64 KiB.
- R8: When several enabled regions match, the one with the lowest index wins.
- R9: With no match the hit flag is low, the request address passes through unchanged and the output kind is 0.
- R10: While the selector names the inbound direction or an index of NUM_REGIONS or more, window reads return zero and window writes change nothing.
- R11: A register write changes the translation outputs from the clock edge that takes it. With no write and a steady request, the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register offset for both read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| reqAddr | input | 64 | Request address to translate |
| xlatAddr | output | 64 | Translated address, or reqAddr on a miss |
| xlatKind | output | 3 | Kind of the winning region, 0 on a miss |
| xlatHit | output | 1 | High when an enabled region contains reqAddr |

## Verification
Two situations are the hardest to reach from the ports. The first is two enabled regions whose windows overlap, so that priority decides the result. The second is a window write issued while the selector points inbound or past the last region, after which the bench must show that nothing changed. The directed stimulus covers both. It programs region 0 as a sub-window inside region 1, and it writes an inbound selector and an out-of-range selector before writing and reading back a real region. A long random phase then mixes selector changes, partial reprogramming and requests clustered around region edges and upper-word boundaries. In that phase a behavioural model is compared with the block every cycle.

// File: rtl/atu_pkg.sv
`timescale 1ns/1ps
package atu_pkg;
  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_VIEWPORT = 12'h900;
  localparam logic [REG_AW-1:0] OFS_CTL1     = 12'h904;
  localparam logic [REG_AW-1:0] OFS_CTL2     = 12'h908;
  localparam logic [REG_AW-1:0] OFS_BASE_LO  = 12'h90C;
  localparam logic [REG_AW-1:0] OFS_BASE_HI  = 12'h910;
  localparam logic [REG_AW-1:0] OFS_LIMIT    = 12'h914;
  localparam logic [REG_AW-1:0] OFS_TGT_LO   = 12'h918;
  localparam logic [REG_AW-1:0] OFS_TGT_HI   = 12'h91C;

  localparam logic [2:0] KIND_MEM  = 3'd0;
  localparam logic [2:0] KIND_IO   = 3'd2;
  localparam logic [2:0] KIND_CFG0 = 3'd4;
  localparam logic [2:0] KIND_CFG1 = 3'd5;

  // write strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic wrCtl1;
    logic wrCtl2;
    logic wrBaseLo;
    logic wrBaseHi;
    logic wrLimit;
    logic wrTgtLo;
    logic wrTgtHi;
  } winStrobeT;

  typedef struct packed {
    logic        en;
    logic [2:0]  kind;
    logic [31:0] baseLo;
    logic [31:0] baseHi;
    logic [31:0] limit;
    logic [31:0] tgtLo;
    logic [31:0] tgtHi;
  } regionT;
endpackage

// File: rtl/atu_ctrl.sv
`timescale 1ns/1ps
module atu_ctrl
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int IDX_BITS    = 4,
  localparam int SEL_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [IDX_BITS:0] vpWrBits,   // {direction, index} from write data
  input  regionT            selRegion,
  output winStrobeT         strobe,
  output logic [SEL_W-1:0]  selIdx,
  output logic [31:0]       regRdData
);
  localparam logic [IDX_BITS:0] NR_CMP = (IDX_BITS+1)'(NUM_REGIONS);

  logic                vpDir;
  logic [IDX_BITS-1:0] vpIdx;
  logic                selValid;
  logic                winWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vpDir <= 1'b0;
      vpIdx <= '0;
    end else if (regWrEn && regAddr == OFS_VIEWPORT) begin
      vpDir <= vpWrBits[IDX_BITS];
      vpIdx <= vpWrBits[IDX_BITS-1:0];
    end
  end

  assign selValid = !vpDir && ({1'b0, vpIdx} < NR_CMP);
  assign selIdx   = vpIdx[SEL_W-1:0];
  assign winWr    = regWrEn && selValid;

  always_comb begin
    strobe          = '0;
    strobe.wrCtl1   = winWr && regAddr == OFS_CTL1;
    strobe.wrCtl2   = winWr && regAddr == OFS_CTL2;
    strobe.wrBaseLo = winWr && regAddr == OFS_BASE_LO;
    strobe.wrBaseHi = winWr && regAddr == OFS_BASE_HI;
    strobe.wrLimit  = winWr && regAddr == OFS_LIMIT;
    strobe.wrTgtLo  = winWr && regAddr == OFS_TGT_LO;
    strobe.wrTgtHi  = winWr && regAddr == OFS_TGT_HI;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == OFS_VIEWPORT) begin
      regRdData[31]           = vpDir;
      regRdData[IDX_BITS-1:0] = vpIdx;
    end else if (selValid) begin
      case (regAddr)
        OFS_CTL1:    regRdData[2:0] = selRegion.kind;
        OFS_CTL2:    regRdData[31]  = selRegion.en;
        OFS_BASE_LO: regRdData      = selRegion.baseLo;
        OFS_BASE_HI: regRdData      = selRegion.baseHi;
        OFS_LIMIT:   regRdData      = selRegion.limit;
        OFS_TGT_LO:  regRdData      = selRegion.tgtLo;
        OFS_TGT_HI:  regRdData      = selRegion.tgtHi;
        default:     regRdData      = '0;
      endcase
    end
  end
endmodule

// File: rtl/atu_datapath.sv
`timescale 1ns/1ps
module atu_datapath
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  localparam int SEL_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  winStrobeT        strobe,
  input  logic [SEL_W-1:0] selIdx,
  input  logic [31:0]      wrData,
  input  logic [63:0]      reqAddr,
  output regionT           selRegion,
  output logic [63:0]      xlatAddr,
  output logic [2:0]       xlatKind,
  output logic             xlatHit
);
  regionT                 regArr [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] matchVec;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    regionT rg;
    logic   here;
    assign here = (selIdx == SEL_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rg <= '0;
      end else if (here) begin
        if (strobe.wrCtl1)   rg.kind   <= wrData[2:0];
        if (strobe.wrCtl2)   rg.en     <= wrData[31];
        if (strobe.wrBaseLo) rg.baseLo <= wrData;
        if (strobe.wrBaseHi) rg.baseHi <= wrData;
        if (strobe.wrLimit)  rg.limit  <= wrData;
        if (strobe.wrTgtLo)  rg.tgtLo  <= wrData;
        if (strobe.wrTgtHi)  rg.tgtHi  <= wrData;
      end
    end

    assign regArr[g]   = rg;
    assign matchVec[g] = rg.en
                      && (reqAddr[63:32] == rg.baseHi)
                      && (reqAddr[31:0]  >= rg.baseLo)
                      && (reqAddr[31:0]  <= rg.limit);
  end

  assign selRegion = regArr[selIdx];

  logic [SEL_W-1:0] winIdx;
  logic             anyHit;
  regionT           win;

  // descending scan so the lowest matching index is assigned last
  always_comb begin
    winIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyHit = 1'b1;
        winIdx = SEL_W'(i);
      end
    end
  end

  assign win = regArr[winIdx];

  always_comb begin
    if (anyHit) begin
      xlatAddr = {win.tgtHi, win.tgtLo} + (reqAddr - {win.baseHi, win.baseLo});
      xlatKind = win.kind;
    end else begin
      xlatAddr = reqAddr;
      xlatKind = KIND_MEM;
    end
    xlatHit = anyHit;
  end
endmodule

// File: rtl/atu_outbound.sv
`timescale 1ns/1ps
module atu_outbound
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int IDX_BITS    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [63:0]       reqAddr,
  output logic [63:0]       xlatAddr,
  output logic [2:0]        xlatKind,
  output logic              xlatHit
);
  localparam int SEL_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  winStrobeT        strobe;
  logic [SEL_W-1:0] selIdx;
  regionT           selRegion;

  atu_ctrl #(.NUM_REGIONS(NUM_REGIONS), .IDX_BITS(IDX_BITS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .vpWrBits  ({regWrData[31], regWrData[IDX_BITS-1:0]}),
    .selRegion (selRegion),
    .strobe    (strobe),
    .selIdx    (selIdx),
    .regRdData (regRdData)
  );

  atu_datapath #(.NUM_REGIONS(NUM_REGIONS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .selIdx    (selIdx),
    .wrData    (regWrData),
    .reqAddr   (reqAddr),
    .selRegion (selRegion),
    .xlatAddr  (xlatAddr),
    .xlatKind  (xlatKind),
    .xlatHit   (xlatHit)
  );
endmodule

// File: rtl/atu_checker.sv
`timescale 1ns/1ps
module atu_checker
  import atu_pkg::*;
#(
  parameter int IDX_BITS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [IDX_BITS:0] vpBits,
  input logic [31:0]       regRdData,
  input logic [63:0]       reqAddr,
  input logic [63:0]       xlatAddr,
  input logic [2:0]        xlatKind,
  input logic              xlatHit
);
  p_vp_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWrEn && regAddr == OFS_VIEWPORT) && regAddr == OFS_VIEWPORT)
      |-> (regRdData == {$past(vpBits[IDX_BITS]), {(31-IDX_BITS){1'b0}},
                         $past(vpBits[IDX_BITS-1:0])}));

  p_ctl2_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFS_CTL2) |-> (regRdData[30:0] == 31'd0));

  p_miss_pass_r9: assert property (@(posedge clk) disable iff (!rstN)
    !xlatHit |-> (xlatAddr == reqAddr && xlatKind == KIND_MEM));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ($stable(reqAddr) |->
      ($stable(xlatAddr) && $stable(xlatKind) && $stable(xlatHit))));

  p_read_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ($stable(regAddr) |-> $stable(regRdData)));
endmodule

bind atu_outbound atu_checker #(.IDX_BITS(IDX_BITS)) u_atu_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .vpBits    ({regWrData[31], regWrData[IDX_BITS-1:0]}),
  .regRdData (regRdData),
  .reqAddr   (reqAddr),
  .xlatAddr  (xlatAddr),
  .xlatKind  (xlatKind),
  .xlatHit   (xlatHit)
);

// File: tb/tb_atu_outbound.sv
`timescale 1ns/1ps
module tb_atu_outbound;
  localparam int NR = 4;

  localparam logic [11:0] A_VP  = 12'h900;
  localparam logic [11:0] A_C1  = 12'h904;
  localparam logic [11:0] A_C2  = 12'h908;
  localparam logic [11:0] A_BL  = 12'h90C;
  localparam logic [11:0] A_BH  = 12'h910;
  localparam logic [11:0] A_LIM = 12'h914;
  localparam logic [11:0] A_TL  = 12'h918;
  localparam logic [11:0] A_TH  = 12'h91C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] reqAddr = '0;
  logic [63:0] xlatAddr;
  logic [2:0]  xlatKind;
  logic        xlatHit;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  atu_outbound #(.NUM_REGIONS(NR), .IDX_BITS(4)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqAddr(reqAddr),
    .xlatAddr(xlatAddr), .xlatKind(xlatKind), .xlatHit(xlatHit)
  );

  // behavioural reference state
  logic        mEn  [NR];
  logic [2:0]  mKind[NR];
  logic [31:0] mBLo [NR];
  logic [31:0] mBHi [NR];
  logic [31:0] mLim [NR];
  logic [31:0] mTLo [NR];
  logic [31:0] mTHi [NR];
  logic        mDir;
  logic [3:0]  mIdx;

  function automatic bit selOk();
    return !mDir && (int'(mIdx) < NR);
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NR; i++) begin
      mEn[i] = 0; mKind[i] = 0; mBLo[i] = 0; mBHi[i] = 0;
      mLim[i] = 0; mTLo[i] = 0; mTHi[i] = 0;
    end
    mDir = 0; mIdx = 0;
  endtask

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    if (a == A_VP) begin
      mDir = d[31]; mIdx = d[3:0];
    end else if (selOk()) begin
      int k = int'(mIdx);
      case (a)
        A_C1:  mKind[k] = d[2:0];
        A_C2:  mEn[k]   = d[31];
        A_BL:  mBLo[k]  = d;
        A_BH:  mBHi[k]  = d;
        A_LIM: mLim[k]  = d;
        A_TL:  mTLo[k]  = d;
        A_TH:  mTHi[k]  = d;
        default: ;
      endcase
    end
  endtask

  task automatic expected(input logic [11:0] a, input logic [63:0] q,
                          output logic eHit, output logic [63:0] eAddr,
                          output logic [2:0] eKind, output logic [31:0] eRd);
    eHit = 0; eAddr = q; eKind = 0; eRd = 0;
    for (int i = 0; i < NR; i++) begin
      if (!eHit && mEn[i] && q[63:32] == mBHi[i] && q[31:0] >= mBLo[i]
          && q[31:0] <= mLim[i]) begin
        eHit  = 1;
        eAddr = {mTHi[i], mTLo[i]} + (q - {mBHi[i], mBLo[i]});
        eKind = mKind[i];
      end
    end
    if (a == A_VP) eRd = {mDir, 27'd0, mIdx};
    else if (selOk()) begin
      int k = int'(mIdx);
      case (a)
        A_C1:  eRd = {29'd0, mKind[k]};
        A_C2:  eRd = {mEn[k], 31'd0};
        A_BL:  eRd = mBLo[k];
        A_BH:  eRd = mBHi[k];
        A_LIM: eRd = mLim[k];
        A_TL:  eRd = mTLo[k];
        A_TH:  eRd = mTHi[k];
        default: eRd = 0;
      endcase
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, compare 1 ns later, commit model after the posedge
  task automatic step(input string tag, input bit we, input logic [11:0] a,
                      input logic [31:0] d, input logic [63:0] q);
    logic eHit; logic [63:0] eAddr; logic [2:0] eKind; logic [31:0] eRd;
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d; reqAddr = q;
    #1;
    expected(a, q, eHit, eAddr, eKind, eRd);
    chk(tag, "hit",  {63'd0, xlatHit}, {63'd0, eHit});
    chk(tag, "addr", xlatAddr, eAddr);
    chk(tag, "kind", {61'd0, xlatKind}, {61'd0, eKind});
    chk(tag, "rd",   {32'd0, regRdData}, {32'd0, eRd});
    @(posedge clk);
    if (we) modelWrite(a, d);
  endtask

  task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d,
                    input logic [63:0] q);
    step(tag, 1'b1, a, d, q);
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [63:0] q);
    step(tag, 1'b0, a, 32'd0, q);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : main
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    rd("R1", A_VP, 64'h0000_0000_1000_0010);
    rd("R1", A_C2, 64'h0);
    rd("R9", A_BL, 64'h0000_0000_0000_0000);

    // R2: selector fields, junk bits dropped
    wr("R2", A_VP, 32'h7FFF_FFF1, 64'h0);
    rd("R2", A_VP, 64'h0);

    // region 1: type-0 configuration, bus 1 dev 2 func 3
    wr("R3", A_BL,  32'h1000_0000, 64'h0);
    wr("R3", A_BH,  32'h0,         64'h0);
    wr("R3", A_LIM, 32'h1000_FFFF, 64'h0);
    wr("R3", A_TL,  32'h0113_0000, 64'h0);
    wr("R3", A_TH,  32'h0,         64'h0);
    wr("R4", A_C1,  32'hFFFF_FFF4, 64'h0);
    wr("R5", A_C2,  32'hC000_0000, 64'h0);
    rd("R3", A_BL,  64'h0);
    rd("R3", A_LIM, 64'h0);
    rd("R3", A_TL,  64'h0);
    rd("R4", A_C1,  64'h0);
    rd("R5", A_C2,  64'h0);

    // R6/R7 boundaries of region 1
    rd("R7", A_VP, 64'h0000_0000_1000_0010);
    rd("R6", A_VP, 64'h0000_0000_1000_0000);
    rd("R6", A_VP, 64'h0000_0000_1000_FFFF);
    rd("R6", A_VP, 64'h0000_0000_1001_0000);
    rd("R6", A_VP, 64'h0000_0000_0FFF_FFFF);
    rd("R6", A_VP, 64'h0000_0001_1000_0010);

    // region 0 nested inside region 1, memory kind, 64-bit target
    wr("R8", A_VP,  32'h0, 64'h0);
    wr("R8", A_BL,  32'h1000_8000, 64'h0);
    wr("R8", A_LIM, 32'h1000_8FFF, 64'h0);
    wr("R8", A_TL,  32'h4000_0000, 64'h0);
    wr("R8", A_TH,  32'h0000_0002, 64'h0);
    wr("R8", A_C2,  32'h8000_0000, 64'h0000_0000_1000_8004);
    rd("R8", A_VP, 64'h0000_0000_1000_8004);
    rd("R8", A_VP, 64'h0000_0000_1000_0004);

    // region 2: I/O kind, carry across bit 32
    wr("R7", A_VP,  32'h2, 64'h0);
    wr("R7", A_BL,  32'hF000_0000, 64'h0);
    wr("R7", A_BH,  32'h0000_0005, 64'h0);
    wr("R7", A_LIM, 32'hFFFF_FFFF, 64'h0);
    wr("R7", A_TL,  32'hFFFF_0000, 64'h0);
    wr("R7", A_TH,  32'h0000_0007, 64'h0);
    wr("R7", A_C1,  32'h2, 64'h0);
    wr("R7", A_C2,  32'h8000_0000, 64'h0);
    rd("R7", A_VP, 64'h0000_0005_FFFF_0000);
    rd("R7", A_VP, 64'h0000_0005_FFFF_FFFF);

    // R11: disabling region 0 hands the request to region 1 next cycle
    wr("R11", A_VP, 32'h0, 64'h0000_0000_1000_8004);
    wr("R11", A_C2, 32'h4000_0000, 64'h0000_0000_1000_8004);
    rd("R11", A_C2, 64'h0000_0000_1000_8004);

    // R10: inbound and out-of-range selectors
    wr("R10", A_VP, 32'h8000_0001, 64'h0);
    rd("R10", A_BL, 64'h0);
    wr("R10", A_BL, 32'hDEAD_BEEF, 64'h0);
    wr("R10", A_C2, 32'h0, 64'h0000_0000_1000_0010);
    wr("R10", A_VP, 32'h0000_0009, 64'h0000_0000_1000_0010);
    rd("R10", A_TL, 64'h0);
    wr("R10", A_TL, 32'h1234_5678, 64'h0);
    wr("R10", A_VP, 32'h1, 64'h0000_0000_1000_0010);
    rd("R10", A_BL, 64'h0000_0000_1000_0010);
    rd("R10", A_TL, 64'h0);
    rd("R3", 12'h920, 64'h0);

    // R11: region 1 switched from configuration to memory use
    wr("R11", A_C1, 32'h0, 64'h0000_0000_1000_0010);
    wr("R11", A_TL, 32'h8000_0000, 64'h0000_0000_1000_0010);
    rd("R11", A_VP, 64'h0000_0000_1000_0010);

    // random phase, compared each cycle
    for (int n = 0; n < 4000; n++) begin
      logic [63:0] q;
      logic [31:0] d;
      logic [11:0] a;
      int pick;
      q = {31'd0, 1'($urandom_range(0, 1)), 32'h1000_0000 | ($urandom & 32'h1_FFFF)};
      pick = $urandom_range(0, 9);
      d = $urandom;
      case ($urandom_range(0, 8))
        0: a = A_VP;
        1: a = A_C1;
        2: a = A_C2;
        3: begin a = A_BL;  d = 32'h1000_0000 | (d & 32'h0001_F000); end
        4: begin a = A_BH;  d = {31'd0, d[0]}; end
        5: begin a = A_LIM; d = 32'h1000_0000 | (d & 32'h0001_FFFF); end
        6: a = A_TL;
        7: a = A_TH;
        default: a = 12'h918 + 12'(4 * $urandom_range(0, 3));
      endcase
      if (a == A_VP) d = {(pick == 0), 27'(d >> 5), 4'($urandom_range(0, 5))};
      if (pick < 4) wr("R6", a, d, q);
      else rd("R6", a, q);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule